// File: doc/BRIEF.md
# SDRAM Power-Up, Refresh and Access Sequencer

This block issues every command on the control pins of a single-rank SDR SDRAM. Out of reset it holds the device quiet for the power-up pause. It then closes all banks, gives the initial run of auto-refresh commands and loads the mode register. After that it sits in an idle loop. From there it sends a periodic auto-refresh, enters and leaves self-refresh on request, and serves single accesses. Each access opens one row, issues one column read or write and closes the row again.

All analogue timings are parameters in nanoseconds. They are turned into cycle counts by rounding up against the clock period parameter, and the sequencer always uses the smallest legal spacing. A requester presents a packed address and a write flag and holds its request until `gnt`. `gnt` is asserted in the cycle the row is opened, and `done` is asserted in the cycle the row is closed. A refresh that comes due is served before any waiting access. When the time since the last refresh has grown past the overdue limit, the next refresh is sent as a pair, one row cycle apart. After self-refresh the sequencer keeps the bus at NOP until the exit window has passed.

Top module: `sdram_cmd_seq`

## Requirements
- R1: From reset, CKE is high and no command other than NOP (or deselect) appears for at least INIT cycles (100 us rounded up to clocks); a request held during this time and during initialization is granted only after the mode-register load.
- R2: The initialization order is one precharge with A10=1 (all banks), then exactly eight REFRESH commands, then one MODE command; nothing else is interleaved.
- R3: The MODE command carries BA=0 and an address of zero except A[2:0]=burst code, A3=wrap (1 = interleaved) and A[6:4]=CAS latency; with default parameters the address is 0x030.
- R4: Commands are encoded on {RAS#,CAS#,WE#} as NOP=111, ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010, REFRESH=001, MODE=000, with CS# low.
- R5: An accepted request produces ACTIVE with the bank from req_addr[21:20] and the row from req_addr[19:8], and gnt is high exactly in that cycle.
- R6: The READ (write flag 0) or WRITE (write flag 1) follows ACTIVE exactly tRCD cycles later, with the column from req_addr[7:0] on the low address bits, A10=0 and the same bank.
- R7: PRECHARGE with A10=0 on the same bank comes at the earliest cycle that is at least tRAS after ACTIVE and at least 2 cycles after WRITE (1 after READ); done is high exactly in that cycle.
- R8: Two commands from the set {ACTIVE, REFRESH} are at least tRC apart, and ACTIVE comes at least tRP after PRECHARGE.
- R9: With no other traffic, REFRESH repeats exactly every REFI cycles (15.6 us rounded up); when a refresh falls due in the same cycle as a request, REFRESH is issued first and ACTIVE follows tRC later.
- R10: If at least LATE cycles (31.2 us rounded up) have elapsed since the last refresh, two REFRESH commands exactly tRC apart are issued before anything else.
- R11: A self-refresh request in idle produces REFRESH with CKE low in the same cycle; CKE stays low while the request is held; once it drops, CKE returns high and the bus stays at NOP until 2+tRC cycles after CKE rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until gnt |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} |
| sr_req | input | 1 | Hold high to stay in self-refresh |
| gnt | output | 1 | Request accepted (row opened) |
| done | output | 1 | Row closed for the accepted request |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Address bus |

## Verification
The case that needs care is a refresh falling due in the very cycle a new access request first becomes visible. Both paths then want to start, and both share the row-cycle spacing. The bench takes the time of an idle refresh and asserts the request so that it is first sampled on the clock edge where the next refresh becomes due. It then requires a REFRESH exactly one interval after the previous one and the ACTIVE exactly tRC after that. A second collision is taken from that refresh, and self-refresh exit is made to coincide with a held request and with an overdue timer.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_MODE = 3'b000,
        CMD_REF  = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_WR   = 3'b100,
        CMD_RD   = 3'b101,
        CMD_NOP  = 3'b111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_POWER,
        ST_INITREF,
        ST_MODE,
        ST_IDLE,
        ST_REF2,
        ST_ROW,
        ST_CLOSE,
        ST_SELF
    } st_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns2cyc(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_span_guard.sv
// Busy for SPAN-1 cycles after a start pulse, so the next start lands SPAN cycles later.
module sdram_span_guard #(
    parameter int SPAN = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    generate
        if (SPAN <= 1) begin : g_none
            assign busy = 1'b0;
        end else begin : g_cnt
            localparam int W = $clog2(SPAN + 1);
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (start)
                    cnt_d = W'(SPAN - 1);
                else if (cnt_q != '0)
                    cnt_d = cnt_q - 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign busy = (cnt_q != '0);
        end
    endgenerate
endmodule

// File: rtl/sdram_ref_timer.sv
// Counts cycles since the last refresh; flags due and overdue.
module sdram_ref_timer #(
    parameter int REFI = 3900,
    parameter int LATE = 7800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic due,
    output logic late
);
    localparam int W = $clog2(LATE + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && cnt_q != W'(LATE))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign due  = run && (cnt_q >= W'(REFI - 1));
    assign late = run && (cnt_q == W'(LATE));
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_PS     = 4000,
    parameter int BA_W       = 2,
    parameter int ROW_W      = 12,
    parameter int COL_W      = 8,
    parameter int INIT_NS    = 100000,
    parameter int REFI_NS    = 15600,
    parameter int LATE_NS    = 31200,
    parameter int TRCD_NS    = 20,
    parameter int TRP_NS     = 20,
    parameter int TRAS_NS    = 45,
    parameter int TRC_NS     = 70,
    parameter int TWR_CK     = 2,
    parameter int TMRD_CK    = 2,
    parameter int INIT_REFS  = 8,
    parameter int CAS_LAT    = 3,
    parameter int BURST_CODE = 0,
    parameter int WRAP_ILV   = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         req_we,
    input  logic [BA_W+ROW_W+COL_W-1:0]  req_addr,
    input  logic                         sr_req,
    output logic                         gnt,
    output logic                         done,
    output logic                         sd_cke,
    output logic                         sd_cs_n,
    output logic                         sd_ras_n,
    output logic                         sd_cas_n,
    output logic                         sd_we_n,
    output logic [BA_W-1:0]              sd_ba,
    output logic [ROW_W-1:0]             sd_addr
);
    localparam int ADDR_W  = BA_W + ROW_W + COL_W;
    localparam int INIT_C  = ns2cyc(INIT_NS, CLK_PS);
    localparam int REFI_C  = ns2cyc(REFI_NS, CLK_PS);
    localparam int LATE_C  = ns2cyc(LATE_NS, CLK_PS);
    localparam int TRCD_C  = imax(ns2cyc(TRCD_NS, CLK_PS), 1);
    localparam int TRP_C   = imax(ns2cyc(TRP_NS, CLK_PS), 1);
    localparam int TRAS_C  = ns2cyc(TRAS_NS, CLK_PS);
    localparam int TRC_C   = imax(ns2cyc(TRC_NS, CLK_PS), 1);
    localparam int SRX_C   = 2 + TRC_C;
    localparam int CLOSE_WR = imax(TRAS_C - TRCD_C, imax(TWR_CK, 1));
    localparam int CLOSE_RD = imax(TRAS_C - TRCD_C, 1);
    localparam int WAIT_W  = $clog2(INIT_C + SRX_C + 2);
    localparam logic [ROW_W-1:0] MODE_WORD =
        ROW_W'((CAS_LAT << 4) | (WRAP_ILV << 3) | BURST_CODE);

    typedef struct packed {
        st_e               st;
        logic [WAIT_W-1:0] wt;
        logic [3:0]        n;
        logic              live;
        logic              cke;
        logic              cs_n;
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ROW_W-1:0]  a;
        logic [COL_W-1:0]  col;
        logic              we;
        logic              gnt;
        logic              done;
    } seq_t;

    seq_t d, q;
    logic rc_start, rc_busy, ref_clr, ref_due, ref_late, wt_zero;

    sdram_span_guard #(.SPAN(TRC_C)) u_rc (
        .clk(clk), .rst_n(rst_n), .start(rc_start), .busy(rc_busy)
    );

    sdram_ref_timer #(.REFI(REFI_C), .LATE(LATE_C)) u_ref (
        .clk(clk), .rst_n(rst_n), .run(q.live), .clear(ref_clr),
        .due(ref_due), .late(ref_late)
    );

    always_comb begin
        d        = q;
        d.cmd    = CMD_NOP;
        d.gnt    = 1'b0;
        d.done   = 1'b0;
        rc_start = 1'b0;
        ref_clr  = 1'b0;
        wt_zero  = (q.wt == '0);
        if (!wt_zero) d.wt = q.wt - 1'b1;

        case (q.st)
            ST_POWER: if (wt_zero) begin
                d.cs_n  = 1'b0;
                d.cmd   = CMD_PRE;
                d.a     = '0;
                d.a[10] = 1'b1;
                d.wt    = WAIT_W'(TRP_C - 1);
                d.n     = 4'(INIT_REFS);
                d.st    = ST_INITREF;
            end
            ST_INITREF: if (wt_zero && !rc_busy) begin
                d.cmd    = CMD_REF;
                rc_start = 1'b1;
                ref_clr  = 1'b1;
                d.n      = q.n - 1'b1;
                if (q.n == 4'd1) d.st = ST_MODE;
            end
            ST_MODE: if (wt_zero && !rc_busy) begin
                d.cmd  = CMD_MODE;
                d.ba   = '0;
                d.a    = MODE_WORD;
                d.wt   = WAIT_W'(TMRD_CK - 1);
                d.live = 1'b1;
                d.st   = ST_IDLE;
            end
            ST_IDLE: if (wt_zero && !rc_busy) begin
                if (ref_due) begin
                    d.cmd    = CMD_REF;
                    rc_start = 1'b1;
                    ref_clr  = 1'b1;
                    if (ref_late) d.st = ST_REF2;
                end else if (sr_req) begin
                    d.cmd    = CMD_REF;
                    d.cke    = 1'b0;
                    rc_start = 1'b1;
                    ref_clr  = 1'b1;
                    d.st     = ST_SELF;
                end else if (req) begin
                    d.cmd    = CMD_ACT;
                    d.ba     = req_addr[ADDR_W-1 -: BA_W];
                    d.a      = req_addr[COL_W +: ROW_W];
                    d.col    = req_addr[COL_W-1:0];
                    d.we     = req_we;
                    d.gnt    = 1'b1;
                    rc_start = 1'b1;
                    d.wt     = WAIT_W'(TRCD_C - 1);
                    d.st     = ST_ROW;
                end
            end
            ST_REF2: if (!rc_busy) begin
                d.cmd    = CMD_REF;
                rc_start = 1'b1;
                ref_clr  = 1'b1;
                d.st     = ST_IDLE;
            end
            ST_ROW: if (wt_zero) begin
                d.cmd = q.we ? CMD_WR : CMD_RD;
                d.a   = '0;
                d.a[COL_W-1:0] = q.col;
                d.wt  = q.we ? WAIT_W'(CLOSE_WR - 1) : WAIT_W'(CLOSE_RD - 1);
                d.st  = ST_CLOSE;
            end
            ST_CLOSE: if (wt_zero) begin
                d.cmd  = CMD_PRE;
                d.a    = '0;
                d.done = 1'b1;
                d.wt   = WAIT_W'(TRP_C - 1);
                d.st   = ST_IDLE;
            end
            ST_SELF: if (!sr_req) begin
                d.cke = 1'b1;
                d.wt  = WAIT_W'(SRX_C - 1);
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_POWER;
            q.wt   <= WAIT_W'(INIT_C - 1);
            q.cke  <= 1'b1;
            q.cs_n <= 1'b1;
            q.cmd  <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign gnt      = q.gnt;
    assign done     = q.done;
    assign sd_cke   = q.cke;
    assign sd_cs_n  = q.cs_n;
    assign {sd_ras_n, sd_cas_n, sd_we_n} = q.cmd;
    assign sd_ba    = q.ba;
    assign sd_addr  = q.a;

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
    parameter int INIT_C = 1,
    parameter int TRC_C  = 1,
    parameter int SRX_C  = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic gnt,
    input logic done
);
    logic [2:0] c;
    logic       live, rc_evt, cke_prev_q;
    int         boot_q, gap_q, sx_q;

    assign c      = {ras_n, cas_n, we_n};
    assign live   = !cs_n && (c != 3'b111);
    assign rc_evt = live && (c == 3'b011 || c == 3'b001);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q     <= 0;
            gap_q      <= TRC_C;
            sx_q       <= SRX_C;
            cke_prev_q <= 1'b1;
        end else begin
            if (boot_q < INIT_C) boot_q <= boot_q + 1;
            if (rc_evt)              gap_q <= 1;
            else if (gap_q < TRC_C)  gap_q <= gap_q + 1;
            if (cke && !cke_prev_q)  sx_q <= 1;
            else if (sx_q < SRX_C)   sx_q <= sx_q + 1;
            cke_prev_q <= cke;
        end
    end

    assert_quiet_boot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q < INIT_C) |-> !live);
    assert_gnt_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (live && c == 3'b011));
    assert_done_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (live && c == 3'b010 && !a10));
    assert_rc_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rc_evt |-> (gap_q >= TRC_C));
    assert_sr_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!cs_n && c == 3'b001));
    assert_sr_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (sx_q >= SRX_C));
endmodule

bind sdram_cmd_seq sdram_seq_chk #(
    .INIT_C(INIT_C), .TRC_C(TRC_C), .SRX_C(SRX_C)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cke(sd_cke), .cs_n(sd_cs_n),
    .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .a10(sd_addr[10]), .gnt(gnt), .done(done)
);

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
    localparam int CLK_PS = 4000;
    localparam int COL_W  = 8;

    function automatic int cyc_of(input int ns);
        return (ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction

    localparam int INIT = cyc_of(100000);
    localparam int REFI = cyc_of(15600);
    localparam int LATE = cyc_of(31200);
    localparam int TRCD = cyc_of(20);
    localparam int TRP  = cyc_of(20);
    localparam int TRAS = cyc_of(45);
    localparam int TRC  = cyc_of(70);

    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
        C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001, C_MODE = 3'b000;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, req_we = 1'b0, sr_req = 1'b0;
    logic [21:0] req_addr = '0;
    logic gnt, done, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;

    sdram_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .sr_req(sr_req), .gnt(gnt), .done(done), .sd_cke(cke), .sd_cs_n(cs_n),
        .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr)
    );

    always #2ns clk = ~clk;

    int cyc = 0;
    always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    int last_rc = -100000, last_pre = -100000;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // continuous checks of the strobes and of row-cycle spacing
    always @(negedge clk) if (rst_n) begin
        if (gnt)  chk(!cs_n && {ras_n,cas_n,we_n} == C_ACT, "R5 gnt only with ACTIVE", {ras_n,cas_n,we_n}, C_ACT);
        if (done) chk(!cs_n && {ras_n,cas_n,we_n} == C_PRE, "R7 done only with PRECHARGE", {ras_n,cas_n,we_n}, C_PRE);
        if (!cs_n && ({ras_n,cas_n,we_n} == C_ACT || {ras_n,cas_n,we_n} == C_REF)) begin
            chk(cyc - last_rc >= TRC, "R8 ACT/REF spacing", cyc - last_rc, TRC);
            if ({ras_n,cas_n,we_n} == C_ACT)
                chk(cyc - last_pre >= TRP, "R8 PRE to ACT", cyc - last_pre, TRP);
            last_rc = cyc;
        end
        if (!cs_n && {ras_n,cas_n,we_n} == C_PRE) last_pre = cyc;
    end

    task automatic next_cmd(output logic [2:0] c, output int t, output logic [11:0] a,
                            output logic [1:0] b, output logic k, output logic g);
        do @(negedge clk); while (cs_n || {ras_n,cas_n,we_n} == C_NOP);
        c = {ras_n,cas_n,we_n}; t = cyc; a = addr; b = ba; k = cke; g = gnt;
    endtask

    task automatic do_access(input int bk, input int row, input int col, input bit w,
                             output bit ref_seen, output int ref_t, output int act_t);
        logic [2:0] c; int t, t_col; logic [11:0] a; logic [1:0] b; logic k, g;
        ref_seen = 0; ref_t = 0;
        req_addr = {2'(bk), 12'(row), 8'(col)};
        req_we = w; req = 1'b1;
        forever begin
            next_cmd(c, t, a, b, k, g);
            if (c != C_REF) break;
            if (!ref_seen) begin ref_seen = 1; ref_t = t; end
        end
        req = 1'b0;
        act_t = t;
        chk(c == C_ACT, "R5 ACTIVE opcode", c, C_ACT);
        chk(g == 1'b1, "R5 gnt with ACTIVE", g, 1);
        chk(b == 2'(bk) && a == 12'(row), "R5 bank/row", {b, a}, {2'(bk), 12'(row)});
        next_cmd(c, t, a, b, k, g);
        t_col = t;
        chk(c == (w ? C_WR : C_RD), "R6 column opcode", c, w ? C_WR : C_RD);
        chk(t - act_t == TRCD, "R6 tRCD", t - act_t, TRCD);
        chk(a[COL_W-1:0] == 8'(col) && !a[10] && b == 2'(bk), "R6 column/bank", {b, a}, {2'(bk), 4'd0, 8'(col)});
        next_cmd(c, t, a, b, k, g);
        chk(c == C_PRE && !a[10] && b == 2'(bk), "R7 PRECHARGE one bank", {c, a[10]}, {C_PRE, 1'b0});
        chk(t == ((act_t + TRAS > t_col + (w ? 2 : 1)) ? act_t + TRAS : t_col + (w ? 2 : 1)),
            "R7 close time", t - act_t, TRAS);
        chk(done == 1'b1, "R7 done with PRECHARGE", done, 1);
    endtask

    initial begin : main
        logic [2:0] c; int t, t0, r1, r2, act_t, ref_t, rise; bit rs;
        logic [11:0] a; logic [1:0] b; logic k, g;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(cke == 1'b1 && cs_n == 1'b1 && !gnt && !done, "R1 reset outputs", {cke, cs_n, gnt, done}, 4'b1100);
        rst_n = 1'b1;
        // request held from the start: must wait for initialization
        req_addr = {2'd1, 12'h123, 8'h45}; req_we = 1'b0; req = 1'b1;
        next_cmd(c, t, a, b, k, g);
        chk(c == C_PRE && a[10], "R2 first command precharge-all", {c, a[10]}, {C_PRE, 1'b1});
        chk(t >= INIT, "R1 power-up pause", t, INIT);
        chk(!g, "R1 no grant during init", g, 0);
        t0 = t;
        for (int i = 0; i < 8; i++) begin
            next_cmd(c, t, a, b, k, g);
            chk(c == C_REF, "R2 init refresh", c, C_REF);
            if (i == 0) chk(t - t0 >= TRP, "R8 tRP before refresh", t - t0, TRP);
        end
        next_cmd(c, t, a, b, k, g);
        chk(c == C_MODE, "R2 mode after eight refreshes", c, C_MODE);
        chk(a == 12'h030 && b == 2'd0, "R3 mode word", {b, a}, 14'h030);
        t0 = t;
        do_access(1, 12'h123, 8'h45, 0, rs, ref_t, act_t);
        chk(act_t - t0 >= 2, "R1 grant after mode load", act_t - t0, 2);

        // random accesses (R4..R8)
        for (int i = 0; i < 24; i++) begin
            repeat ($urandom_range(0, 30)) @(negedge clk);
            do_access(int'($urandom_range(0, 3)), int'($urandom_range(0, 4095)),
                      int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)), rs, ref_t, act_t);
        end
        // directed corners: extreme addresses
        do_access(3, 12'hFFF, 8'hFF, 1, rs, ref_t, act_t);
        do_access(0, 0, 0, 0, rs, ref_t, act_t);

        // periodic refresh in idle (R9)
        next_cmd(c, r1, a, b, k, g);
        chk(c == C_REF, "R9 idle refresh", c, C_REF);
        next_cmd(c, r2, a, b, k, g);
        chk(c == C_REF && r2 - r1 == REFI, "R9 refresh interval", r2 - r1, REFI);

        // refresh due in the same cycle a request appears (R9)
        for (int j = 0; j < 2; j++) begin
            while (cyc < r2 + REFI - 1) @(negedge clk);
            do_access(2, 12'h5A5 + j, 8'h3C, 1'(j), rs, ref_t, act_t);
            chk(rs && ref_t == r2 + REFI, "R9 refresh wins collision", ref_t, r2 + REFI);
            chk(act_t == ref_t + TRC, "R9 access after refresh", act_t - ref_t, TRC);
            r2 = ref_t;
        end

        // short self-refresh with a request held across it (R11)
        repeat (3) @(negedge clk);
        sr_req = 1'b1;
        next_cmd(c, t, a, b, k, g);
        chk(c == C_REF && k == 1'b0, "R11 self-refresh entry", {c, k}, {C_REF, 1'b0});
        req_addr = {2'd3, 12'h0F0, 8'h11}; req_we = 1'b1; req = 1'b1;
        repeat (200) @(negedge clk);
        chk(cke == 1'b0 && !gnt, "R11 held in self-refresh", {cke, gnt}, 0);
        sr_req = 1'b0;
        do @(negedge clk); while (!cke);
        rise = cyc;
        do_access(3, 12'h0F0, 8'h11, 1, rs, ref_t, act_t);
        chk(!rs, "R10 no burst after short stay", rs, 0);
        chk(act_t == rise + 2 + TRC, "R11 exit wait", act_t - rise, 2 + TRC);

        // long self-refresh: overdue on exit (R10)
        repeat (3) @(negedge clk);
        sr_req = 1'b1;
        next_cmd(c, t, a, b, k, g);
        chk(c == C_REF && k == 1'b0, "R11 second entry", {c, k}, {C_REF, 1'b0});
        repeat (LATE + 100) @(negedge clk);
        sr_req = 1'b0;
        do @(negedge clk); while (!cke);
        rise = cyc;
        next_cmd(c, t, a, b, k, g);
        chk(c == C_REF && t == rise + 2 + TRC, "R10 first overdue refresh", t - rise, 2 + TRC);
        t0 = t;
        next_cmd(c, t, a, b, k, g);
        chk(c == C_REF && t - t0 == TRC, "R10 second overdue refresh", t - t0, TRC);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule